// File: doc/BRIEF.md
# Flash Burst Configuration Command Decoder

This block models the command front end of a flash memory that decodes bus write cycles. It follows the active read mode (array, status, identification query, or the pending configuration state) and holds the burst configuration register that sets how later reads run. Each bus write appears as a single-cycle `wr_en` strobe, with the command opcode on the data bus and an address on the address bus.

A configuration load is a two-write handshake. The first write carries the setup opcode. The second write must carry the confirm opcode. On that second write, the address bus (not the data bus) holds the new configuration word in bits 2 through 17. A correct handshake latches those bits, breaks them out into burst length, burst type, latency, synchronous/asynchronous read select and active clock edge, raises a one-cycle update pulse, and returns the decoder to array read. A wrong second write drops the handshake and leaves the register unchanged.

Top module: `flash_burst_cfg_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `read_mode` is 0 (array read), `cfg_word` is 0 (asynchronous read, falling clock edge, all fields zero) and `cfg_update` is 0. A reset in mid-operation restores this state.
- R2: A write with data 16'h0060 made outside the pending state moves `read_mode` to 3 (configuration pending) after that clock edge.
- R3: In the pending state, a write with data 16'h0003 loads `addr[17:2]` into `cfg_word`. The new value shows on the edge that samples the write.
- R4: The configuration fields are decoded from `cfg_word` with bit 0 as the lowest. `burst_len` is bits [2:0]. `burst_wrap` is bit 3 (1 = wrapping, 0 = linear). `latency` is bits [6:4]. `sync_read` is bit 7 (1 = synchronous). `rising_edge` is bit 8 (1 = rising). Bits [15:9] are stored and appear only on `cfg_word`.
- R5: Any write made in the pending state returns `read_mode` to 0, whether or not it confirms.
- R6: `cfg_update` is 1 for exactly the single cycle in which a confirmed load first shows on `cfg_word`, and is 0 in every other cycle.
- R7: In the pending state, a write whose data is not exactly 16'h0003 leaves `cfg_word` unchanged and gives no `cfg_update`. This includes a repeated 16'h0060 and a confirm byte with nonzero upper data bits.
- R8: A write of 16'h0003 outside the pending state does not change `cfg_word` and does not change `read_mode`.
- R9: Outside the pending state, a write of 16'h00FF selects mode 0, 16'h0070 selects mode 1 (status) and 16'h0098 selects mode 2 (query). Any other data value leaves the mode as it is.
- R10: Cycles with `wr_en` low change neither `read_mode` nor `cfg_word`, whatever `addr` and `data` hold.
- R11: Address bits outside [17:2] on the confirm write, and the whole address of the setup write, have no effect on `cfg_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| addr | input | 24 | Write address; bits [17:2] carry the configuration word |
| data | input | 16 | Write data holding the command opcode |
| cfg_word | output | 16 | Latched configuration register |
| burst_len | output | 3 | Burst length code |
| burst_wrap | output | 1 | Burst type: 1 wrapping, 0 linear |
| latency | output | 3 | Latency code |
| sync_read | output | 1 | 1 synchronous read, 0 asynchronous |
| rising_edge | output | 1 | 1 rising clock edge active, 0 falling |
| read_mode | output | 2 | 0 array, 1 status, 2 query, 3 configuration pending |
| cfg_update | output | 1 | One-cycle pulse on each successful load |

## Verification
A full handshake is run with address words whose fields differ from one another. This shows that each field comes from its own slice. The same word is also sent with extra bits set outside [17:2], which shows that the capture window does not reach past its bounds. The failing second cycles used are a status opcode, a repeated setup, and a confirm byte with upper data set. These separate a correct abort from a decoder that matches only the low byte or that keeps waiting. A confirm with no setup before it, idle cycles that carry the confirm opcode, and handshakes started from status and query modes show that only the pending state can load the register.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

   typedef enum logic [1:0] {
      MODE_ARRAY   = 2'd0,
      MODE_STATUS  = 2'd1,
      MODE_QUERY   = 2'd2,
      MODE_PENDING = 2'd3
   } rd_mode_e;

   typedef enum logic [2:0] {
      OPK_OTHER   = 3'd0,
      OPK_ARRAY   = 3'd1,
      OPK_STATUS  = 3'd2,
      OPK_QUERY   = 3'd3,
      OPK_SETUP   = 3'd4,
      OPK_CONFIRM = 3'd5
   } op_kind_e;

   // Field packing of the configuration word, lowest field first.
   localparam int BLEN_LSB  = 0;
   localparam int BLEN_W    = 3;
   localparam int WRAP_BIT  = BLEN_LSB + BLEN_W;
   localparam int LAT_LSB   = WRAP_BIT + 1;
   localparam int LAT_W     = 3;
   localparam int SYNC_BIT  = LAT_LSB + LAT_W;
   localparam int EDGE_BIT  = SYNC_BIT + 1;
   localparam int FIELDS_W  = EDGE_BIT + 1;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
   import flash_cfg_pkg::*;
#(
   parameter int         DATA_W      = 16,
   parameter logic [7:0] OPC_SETUP   = 8'h60,
   parameter logic [7:0] OPC_CONFIRM = 8'h03,
   parameter logic [7:0] OPC_ARRAY   = 8'hFF,
   parameter logic [7:0] OPC_STATUS  = 8'h70,
   parameter logic [7:0] OPC_QUERY   = 8'h98
) (
   input  logic [DATA_W-1:0] data,
   output op_kind_e          kind
);

   localparam logic [DATA_W-1:0] W_SETUP   = DATA_W'(OPC_SETUP);
   localparam logic [DATA_W-1:0] W_CONFIRM = DATA_W'(OPC_CONFIRM);
   localparam logic [DATA_W-1:0] W_ARRAY   = DATA_W'(OPC_ARRAY);
   localparam logic [DATA_W-1:0] W_STATUS  = DATA_W'(OPC_STATUS);
   localparam logic [DATA_W-1:0] W_QUERY   = DATA_W'(OPC_QUERY);

   initial begin
      a_data_width : assert (DATA_W >= 8)
         else $error("data bus narrower than an opcode");
      a_opc_distinct : assert (OPC_SETUP != OPC_CONFIRM && OPC_SETUP != OPC_ARRAY &&
                               OPC_SETUP != OPC_STATUS && OPC_SETUP != OPC_QUERY &&
                               OPC_CONFIRM != OPC_ARRAY && OPC_CONFIRM != OPC_STATUS &&
                               OPC_CONFIRM != OPC_QUERY && OPC_ARRAY != OPC_STATUS &&
                               OPC_ARRAY != OPC_QUERY && OPC_STATUS != OPC_QUERY)
         else $error("opcode values collide");
   end

   // Full-word compare: upper data bits must be zero for a command to match.
   always_comb begin
      kind = OPK_OTHER;
      if (data == W_SETUP)        kind = OPK_SETUP;
      else if (data == W_CONFIRM) kind = OPK_CONFIRM;
      else if (data == W_ARRAY)   kind = OPK_ARRAY;
      else if (data == W_STATUS)  kind = OPK_STATUS;
      else if (data == W_QUERY)   kind = OPK_QUERY;
   end

endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
   import flash_cfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  op_kind_e kind,
   output rd_mode_e mode,
   output logic     load_cfg
);

   rd_mode_e mode_nxt;

   // A confirm is only recognised as the write that directly follows setup.
   assign load_cfg = wr_en && (mode == MODE_PENDING) && (kind == OPK_CONFIRM);

   always_comb begin
      mode_nxt = mode;
      if (wr_en) begin
         if (mode == MODE_PENDING) begin
            mode_nxt = MODE_ARRAY;
         end else begin
            unique case (kind)
               OPK_SETUP:  mode_nxt = MODE_PENDING;
               OPK_ARRAY:  mode_nxt = MODE_ARRAY;
               OPK_STATUS: mode_nxt = MODE_STATUS;
               OPK_QUERY:  mode_nxt = MODE_QUERY;
               default:    mode_nxt = mode;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode <= MODE_ARRAY;
      else        mode <= mode_nxt;
   end

   p_setup_entry_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode != MODE_PENDING && kind == OPK_SETUP) |=> mode == MODE_PENDING);

   p_pending_exit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode == MODE_PENDING) |=> mode == MODE_ARRAY);

   p_status_select_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode != MODE_PENDING && kind == OPK_STATUS) |=> mode == MODE_STATUS);

   p_other_keeps_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode != MODE_PENDING && (kind == OPK_OTHER || kind == OPK_CONFIRM))
      |=> $stable(mode));

   p_idle_mode_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode));

endmodule

// File: rtl/flash_cfg_store.sv
module flash_cfg_store #(
   parameter int ADDR_W = 24,
   parameter int CFG_LO = 2,
   parameter int CFG_HI = 17,
   parameter logic [CFG_HI-CFG_LO:0] CFG_RST = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        addr,
   output logic [CFG_HI-CFG_LO:0]   cfg_word,
   output logic                     load_pulse
);

   localparam int CFG_W = CFG_HI - CFG_LO + 1;

   initial begin
      a_window_fits : assert (CFG_LO >= 0 && CFG_HI >= CFG_LO && CFG_HI < ADDR_W)
         else $error("capture window outside address bus");
   end

   // Address bits outside the capture window are not used by design.
   if (CFG_LO > 0 && CFG_HI < ADDR_W - 1) begin : g_unused_both
      logic unused_addr_bits;
      assign unused_addr_bits = ^{addr[CFG_LO-1:0], addr[ADDR_W-1:CFG_HI+1]};
   end else if (CFG_LO > 0) begin : g_unused_low
      logic unused_addr_bits;
      assign unused_addr_bits = ^addr[CFG_LO-1:0];
   end else if (CFG_HI < ADDR_W - 1) begin : g_unused_high
      logic unused_addr_bits;
      assign unused_addr_bits = ^addr[ADDR_W-1:CFG_HI+1];
   end

   for (genvar b = 0; b < CFG_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)    cfg_word[b] <= CFG_RST[b];
         else if (load) cfg_word[b] <= addr[CFG_LO + b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) load_pulse <= 1'b0;
      else        load_pulse <= load;
   end

   p_capture_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cfg_word == $past(addr[CFG_HI:CFG_LO])) && load_pulse);

   p_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_word) && !load_pulse);

endmodule

// File: rtl/flash_cfg_fields.sv
module flash_cfg_fields
   import flash_cfg_pkg::*;
(
   input  logic [FIELDS_W-1:0] fields,
   output logic [BLEN_W-1:0]   burst_len,
   output logic                burst_wrap,
   output logic [LAT_W-1:0]    latency,
   output logic                sync_read,
   output logic                rising_edge
);

   assign burst_len   = fields[BLEN_LSB +: BLEN_W];
   assign burst_wrap  = fields[WRAP_BIT];
   assign latency     = fields[LAT_LSB +: LAT_W];
   assign sync_read   = fields[SYNC_BIT];
   assign rising_edge = fields[EDGE_BIT];

endmodule

// File: rtl/flash_burst_cfg_decoder.sv
module flash_burst_cfg_decoder
   import flash_cfg_pkg::*;
#(
   parameter int         ADDR_W      = 24,
   parameter int         DATA_W      = 16,
   parameter int         CFG_LO      = 2,
   parameter int         CFG_HI      = 17,
   parameter logic [7:0] OPC_SETUP   = 8'h60,
   parameter logic [7:0] OPC_CONFIRM = 8'h03
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         data,
   output logic [CFG_HI-CFG_LO:0]    cfg_word,
   output logic [BLEN_W-1:0]         burst_len,
   output logic                      burst_wrap,
   output logic [LAT_W-1:0]          latency,
   output logic                      sync_read,
   output logic                      rising_edge,
   output logic [1:0]                read_mode,
   output logic                      cfg_update
);

   localparam int CFG_W = CFG_HI - CFG_LO + 1;
   // Reset value: every field zero, so reads start asynchronous.
   localparam logic [CFG_W-1:0] CFG_RST = '0;

   initial begin
      a_fields_fit : assert (CFG_W >= FIELDS_W)
         else $error("capture window cannot hold all fields");
      a_reset_async : assert (CFG_RST[SYNC_BIT] == 1'b0)
         else $error("reset value must select asynchronous read");
   end

   op_kind_e kind;
   rd_mode_e mode;
   logic     load_cfg;

   flash_cmd_classify #(
      .DATA_W      (DATA_W),
      .OPC_SETUP   (OPC_SETUP),
      .OPC_CONFIRM (OPC_CONFIRM)
   ) classify_i (
      .data (data),
      .kind (kind)
   );

   flash_mode_fsm fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .kind     (kind),
      .mode     (mode),
      .load_cfg (load_cfg)
   );

   flash_cfg_store #(
      .ADDR_W  (ADDR_W),
      .CFG_LO  (CFG_LO),
      .CFG_HI  (CFG_HI),
      .CFG_RST (CFG_RST)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_cfg),
      .addr       (addr),
      .cfg_word   (cfg_word),
      .load_pulse (cfg_update)
   );

   flash_cfg_fields fields_i (
      .fields      (cfg_word[FIELDS_W-1:0]),
      .burst_len   (burst_len),
      .burst_wrap  (burst_wrap),
      .latency     (latency),
      .sync_read   (sync_read),
      .rising_edge (rising_edge)
   );

   assign read_mode = mode;

   p_pulse_single_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_update |=> !cfg_update);

   p_change_needs_pulse_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_word) |-> cfg_update);

   p_pulse_lands_array_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_update |-> read_mode == 2'd0);

endmodule

// File: tb/flash_burst_cfg_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_burst_cfg_decoder_tb_top;

   typedef struct {
      logic [1:0]  mode;
      logic [15:0] cfg;
      logic        pulse;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [23:0] addr = '0;
   logic [15:0] data = '0;
   logic [15:0] cfg_word;
   logic [2:0]  burst_len;
   logic        burst_wrap;
   logic [2:0]  latency;
   logic        sync_read;
   logic        rising_edge;
   logic [1:0]  read_mode;
   logic        cfg_update;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   exp_item_t   exp_q[$];
   exp_item_t   cur;
   logic [1:0]  m_mode = 2'd0;
   logic [15:0] m_cfg = 16'h0;

   always #4 clk = ~clk;

   flash_burst_cfg_decoder dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .data (data),
      .cfg_word (cfg_word), .burst_len (burst_len), .burst_wrap (burst_wrap),
      .latency (latency), .sync_read (sync_read), .rising_edge (rising_edge),
      .read_mode (read_mode), .cfg_update (cfg_update)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: one bus cycle, model updated and expected outcome queued.
   task automatic bus(input bit we, input logic [23:0] a, input logic [15:0] d,
                      input string tag);
      exp_item_t it;
      logic p;
      @(negedge clk);
      wr_en = we; addr = a; data = d;
      p = 1'b0;
      if (we) begin
         if (m_mode == 2'd3) begin
            if (d == 16'h0003) begin
               m_cfg = a[17:2];
               p = 1'b1;
            end
            m_mode = 2'd0;
         end else begin
            case (d)
               16'h0060: m_mode = 2'd3;
               16'h00FF: m_mode = 2'd0;
               16'h0070: m_mode = 2'd1;
               16'h0098: m_mode = 2'd2;
               default: ;
            endcase
         end
      end
      it.mode = m_mode; it.cfg = m_cfg; it.pulse = p; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) bus(1'b0, 24'hFFFFFF, 16'h0003, tag);
   endtask

   task automatic do_cfg(input logic [23:0] a, input string tag);
      bus(1'b1, 24'h00ABCD, 16'h0060, tag);
      bus(1'b1, a, 16'h0003, tag);
      idle(1, tag);
   endtask

   // Monitor: pops one expectation per clock, after the edge settles.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         cur = exp_q.pop_front();
         check(read_mode == cur.mode, cur.tag, "read_mode", 16'(read_mode), 16'(cur.mode));
         check(cfg_word == cur.cfg, cur.tag, "cfg_word", cfg_word, cur.cfg);
         check(cfg_update == cur.pulse, {cur.tag, "/R6"}, "cfg_update",
               16'(cfg_update), 16'(cur.pulse));
         check({rising_edge, sync_read, latency, burst_wrap, burst_len} == cur.cfg[8:0],
               "R4", "fields",
               16'({rising_edge, sync_read, latency, burst_wrap, burst_len}),
               16'(cur.cfg[8:0]));
      end
   end

   task automatic reset_check(input string tag);
      @(negedge clk);
      wr_en = 1'b0;
      rst_n = 1'b0;
      m_mode = 2'd0; m_cfg = 16'h0;
      repeat (3) @(negedge clk);
      check(read_mode == 2'd0 && cfg_word == 16'h0 && cfg_update == 1'b0 && sync_read == 1'b0,
            tag, "reset state", {cfg_word[13:0], read_mode}, 16'h0);
      rst_n = 1'b1;
      idle(1, tag);
   endtask

   initial begin
      reset_check("R1");
      // R2, R3, R5: basic handshake with distinct field values
      // addr[17:2] = 16'h01B5 -> len 5, wrap 0, lat 3, sync 1, edge 1
      bus(1'b1, 24'h000000, 16'h0060, "R2");
      bus(1'b1, 24'h0006D4, 16'h0003, "R3");
      idle(2, "R5");
      // R3: all ones in the window, R11: bits outside window set
      do_cfg(24'h03FFFC, "R3");
      do_cfg(24'hFC0003 | 24'h000248, "R11");
      // R10: idle cycles with confirm opcode on bus, mode pending stays pending
      bus(1'b1, 24'h0, 16'h0060, "R10");
      idle(3, "R10");
      bus(1'b1, 24'h001230, 16'h0003, "R10");
      idle(1, "R10");
      // R7: aborted handshakes
      bus(1'b1, 24'h0, 16'h0060, "R7");
      bus(1'b1, 24'h00FFF0, 16'h0070, "R7");
      idle(1, "R7");
      bus(1'b1, 24'h0, 16'h0060, "R7");
      bus(1'b1, 24'h00AAA8, 16'h0060, "R7");
      idle(1, "R7");
      bus(1'b1, 24'h0, 16'h0060, "R7");
      bus(1'b1, 24'h015550, 16'h0103, "R7");
      idle(1, "R7");
      // R8: confirm without setup
      bus(1'b1, 24'h03FFFC, 16'h0003, "R8");
      idle(1, "R8");
      // R9: mode selection and unknown opcodes
      bus(1'b1, 24'h0, 16'h0070, "R9");
      bus(1'b1, 24'h0, 16'h0055, "R9");
      bus(1'b1, 24'h0, 16'h0003, "R9");
      bus(1'b1, 24'h0, 16'h0098, "R9");
      bus(1'b1, 24'h0, 16'h0170, "R9");
      bus(1'b1, 24'h0, 16'h00FF, "R9");
      // R2: handshake started from status and query modes
      bus(1'b1, 24'h0, 16'h0070, "R2");
      do_cfg(24'h000404, "R2");
      bus(1'b1, 24'h0, 16'h0098, "R2");
      do_cfg(24'h000880, "R2");
      // R6: back-to-back loads
      do_cfg(24'h00100C, "R6");
      do_cfg(24'h002010, "R6");
      // R1: reset after a load restores defaults
      do_cfg(24'h0007FC, "R1");
      reset_check("R1");
      idle(2, "R1");
      @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R6", "queue drained", 16'(exp_q.size()), 16'h0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule